// File: doc/BRIEF.md
# PWM Output Steering and Trip Protection

This block sits between a three-phase PWM timebase and the six gate-drive pins. For each of the three phase pairs it takes a raw high-side and low-side signal. It can swap the two signals of a pair, and it masks each pin with its own enable. It can then gate either side group with a high-frequency chopping carrier, so the outputs can drive pulse transformers. The steered and gated value is registered once, so every pin is a clean flop output during normal running.

Protection sits after that register. The trip input is active low. While it is low, all six outputs are forced to their off level (logic 0) through combinational gates only, so a stopped clock cannot delay the shutdown. A synchronised copy of the pin is reported as a status level. The same copy sets a sticky trip flag, and the flag keeps the outputs off after the pin recovers. The flag can only be cleared by an explicit request while the synchronised pin level is high. All patterns are active high, and no polarity inversion exists.

Top module: `pwm_out_stage`

## Requirements
- R1: While rst_ni is low, all six outputs are 0, trip_flag_o is 0 and trip_lvl_o is 1, whatever the PWM inputs are.
- R2: With no crossover, all enables set, chopping off and no trip, pwm_hi_o[k] and pwm_lo_o[k] equal pwm_hi_i[k] and pwm_lo_i[k] as sampled at the previous rising clock edge (one cycle of latency).
- R3: When xover_i[k] is 1, pair k is swapped: pwm_hi_o[k] follows pwm_lo_i[k] and pwm_lo_o[k] follows pwm_hi_i[k]. Other pairs are not affected.
- R4: Enables apply to output pins after crossover. en_hi_i[k]=0 holds pwm_hi_o[k] at 0, and en_lo_i[k]=0 holds pwm_lo_o[k] at 0.
- R5: The chopping carrier is a 50% square wave. It is high for the first 4*(N+1) clock edges after reset and then toggles every 4*(N+1) edges, where N is chop_div_i.
- R6: chop_hi_en_i=1 ANDs all three high-side outputs with the carrier and leaves the low side untouched.
- R7: chop_lo_en_i=1 ANDs all three low-side outputs with the carrier and leaves the high side untouched.
- R8: While trip_ni is 0, all six outputs are 0 with no clock edge needed.
- R9: trip_lvl_o shows trip_ni delayed by two rising clock edges (two-flop synchroniser).
- R10: The first edge after trip_lvl_o reads 0 sets trip_flag_o. While the flag is set, all outputs are 0, even after the pin returns high. trip_clr_i clears the flag only on an edge where trip_lvl_o reads 1; otherwise it has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_hi_i | input | 3 | Raw high-side PWM per pair |
| pwm_lo_i | input | 3 | Raw low-side PWM per pair |
| xover_i | input | 3 | Per-pair crossover select |
| en_hi_i | input | 3 | High-side output pin enables |
| en_lo_i | input | 3 | Low-side output pin enables |
| chop_div_i | input | 8 | Carrier divider value N |
| chop_hi_en_i | input | 1 | Chop the high-side group |
| chop_lo_en_i | input | 1 | Chop the low-side group |
| trip_ni | input | 1 | Trip pin, active low |
| trip_clr_i | input | 1 | Clear request for the trip flag |
| pwm_hi_o | output | 3 | High-side gate drive outputs |
| pwm_lo_o | output | 3 | Low-side gate drive outputs |
| trip_lvl_o | output | 1 | Synchronised trip pin level |
| trip_flag_o | output | 1 | Sticky trip flag |

## Verification
Several properties are checked on every clock cycle:
- all outputs stay at 0 while the trip pin is low or the flag is set;
- a disabled pin stays at 0 on the cycle after its enable was low;
- the carrier toggles only when its counter wraps;
- a low synchronised trip level always sets the flag on the next edge.

Other behaviours can only be shown by the bench's scenarios:
- the exact carrier phase against 4*(N+1) for two divider values;
- crossover combined with enables and chopping;
- the fact that the output drops between clock edges when the trip pin falls;
- a clear request being ignored while the pin is low and honoured once it is high.

// File: rtl/pwm_out_pkg.sv
`timescale 1ns/1ps
package pwm_out_pkg;
  parameter int unsigned NUM_PAIRS = 3;
  parameter int unsigned DIV_W     = 8;
  // carrier half period is 4*(N+1): needs DIV_W+2 bits, one spare for compare
  localparam int unsigned CNT_W    = DIV_W + 3;
endpackage

// File: rtl/pwm_chop_gen.sv
`timescale 1ns/1ps
module pwm_chop_gen #(
  parameter int unsigned DIV_W = pwm_out_pkg::DIV_W,
  parameter int unsigned CNT_W = pwm_out_pkg::CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             carrier_o
);
  logic [CNT_W-1:0] div_ext, last_cnt, cnt_q;
  logic             car_q;

  assign div_ext  = {{(CNT_W-DIV_W){1'b0}}, div_i};
  assign last_cnt = (div_ext << 2) + CNT_W'(3);  // 4*(N+1)-1

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      car_q <= 1'b1;
    end else if (cnt_q >= last_cnt) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = car_q;

  assert_toggle_on_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (car_q != $past(car_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/pwm_pair_steer.sv
`timescale 1ns/1ps
module pwm_pair_steer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hi_i,
  input  logic lo_i,
  input  logic xover_i,
  input  logic en_hi_i,
  input  logic en_lo_i,
  input  logic gate_hi_i,
  input  logic gate_lo_i,
  output logic hi_o,
  output logic lo_o
);
  logic hi_x, lo_x, hi_d, lo_d, hi_q, lo_q;

  // crossover, then pin enable, then carrier gate
  assign hi_x = xover_i ? lo_i : hi_i;
  assign lo_x = xover_i ? hi_i : lo_i;
  assign hi_d = hi_x & en_hi_i & gate_hi_i;
  assign lo_d = lo_x & en_lo_i & gate_lo_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  assert_hi_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(en_hi_i)) |-> !hi_q);
  assert_lo_disabled_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(en_lo_i)) |-> !lo_q);
endmodule

// File: rtl/pwm_trip_guard.sv
`timescale 1ns/1ps
module pwm_trip_guard (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_ni,
  input  logic clr_i,
  output logic lvl_o,
  output logic flag_o
);
  logic sync1_q, lvl_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b1;
      lvl_q   <= 1'b1;
    end else begin
      sync1_q <= trip_ni;
      lvl_q   <= sync1_q;
    end
  end

  // set wins over clear while the pin is still low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (!lvl_q)  flag_q <= 1'b1;
    else if (clr_i)   flag_q <= 1'b0;
  end

  assign lvl_o  = lvl_q;
  assign flag_o = flag_q;

  assert_flag_sets_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lvl_q |=> flag_q);
  assert_clear_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> ($past(clr_i) && $past(lvl_q)));
endmodule

// File: rtl/pwm_out_stage.sv
`timescale 1ns/1ps
module pwm_out_stage #(
  parameter int unsigned NUM_PAIRS = pwm_out_pkg::NUM_PAIRS,
  parameter int unsigned DIV_W     = pwm_out_pkg::DIV_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PAIRS-1:0] pwm_hi_i,
  input  logic [NUM_PAIRS-1:0] pwm_lo_i,
  input  logic [NUM_PAIRS-1:0] xover_i,
  input  logic [NUM_PAIRS-1:0] en_hi_i,
  input  logic [NUM_PAIRS-1:0] en_lo_i,
  input  logic [DIV_W-1:0]     chop_div_i,
  input  logic                 chop_hi_en_i,
  input  logic                 chop_lo_en_i,
  input  logic                 trip_ni,
  input  logic                 trip_clr_i,
  output logic [NUM_PAIRS-1:0] pwm_hi_o,
  output logic [NUM_PAIRS-1:0] pwm_lo_o,
  output logic                 trip_lvl_o,
  output logic                 trip_flag_o
);
  localparam int unsigned CNT_W = DIV_W + 3;

  logic                 carrier, gate_hi, gate_lo, trip_flag, run_ok;
  logic [NUM_PAIRS-1:0] stage_hi, stage_lo;

  pwm_chop_gen #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chop (
    .clk_i, .rst_ni, .div_i(chop_div_i), .carrier_o(carrier)
  );

  assign gate_hi = ~chop_hi_en_i | carrier;
  assign gate_lo = ~chop_lo_en_i | carrier;

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    pwm_pair_steer u_pair (
      .clk_i, .rst_ni,
      .hi_i(pwm_hi_i[k]), .lo_i(pwm_lo_i[k]), .xover_i(xover_i[k]),
      .en_hi_i(en_hi_i[k]), .en_lo_i(en_lo_i[k]),
      .gate_hi_i(gate_hi), .gate_lo_i(gate_lo),
      .hi_o(stage_hi[k]), .lo_o(stage_lo[k])
    );
  end

  pwm_trip_guard u_trip (
    .clk_i, .rst_ni, .trip_ni, .clr_i(trip_clr_i),
    .lvl_o(trip_lvl_o), .flag_o(trip_flag)
  );

  // unclocked kill path: pin goes straight into the output gates
  assign run_ok      = trip_ni & ~trip_flag;
  assign pwm_hi_o    = stage_hi & {NUM_PAIRS{run_ok}};
  assign pwm_lo_o    = stage_lo & {NUM_PAIRS{run_ok}};
  assign trip_flag_o = trip_flag;

  assert_trip_pin_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |-> (pwm_hi_o == '0 && pwm_lo_o == '0));
  assert_flag_holds_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_flag_o |-> (pwm_hi_o == '0 && pwm_lo_o == '0));
endmodule

// File: tb/sim_pwm_out_stage.sv
`timescale 1ns/1ps
module sim_pwm_out_stage;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] hi_i, lo_i, xo_i, eh_i, el_i;
  logic [7:0] div_i;
  logic       ch_i, cl_i, trip_n, clr_i;
  logic [2:0] hi_o, lo_o;
  logic       lvl_o, flag_o;

  always #10 clk = ~clk;  // 50 MHz

  pwm_out_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwm_hi_i(hi_i), .pwm_lo_i(lo_i),
    .xover_i(xo_i), .en_hi_i(eh_i), .en_lo_i(el_i), .chop_div_i(div_i),
    .chop_hi_en_i(ch_i), .chop_lo_en_i(cl_i), .trip_ni(trip_n),
    .trip_clr_i(clr_i), .pwm_hi_o(hi_o), .pwm_lo_o(lo_o),
    .trip_lvl_o(lvl_o), .trip_flag_o(flag_o)
  );

  typedef struct {
    int         due;
    logic [2:0] hi;
    logic [2:0] lo;
    string      req;
  } item_t;

  item_t sb[$];
  int    cyc, n_cmp, n_bad, half_len;
  bit    done;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic cmp(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // monitor: pops items due at this cycle
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      cmp(it.req, "hi", int'(hi_o), int'(it.hi));
      cmp(it.req, "lo", int'(lo_o), int'(it.lo));
    end
  end

  function automatic logic car_after(input int edges);
    return ((edges / half_len) % 2) == 0;
  endfunction

  task automatic drive(input logic [2:0] hi, lo, eh, el, xo,
                       input logic ch, cl, input string req);
    item_t      it;
    logic       car;
    logic [2:0] h, l;
    @(negedge clk); #2;
    hi_i = hi; lo_i = lo; eh_i = eh; el_i = el; xo_i = xo; ch_i = ch; cl_i = cl;
    car = car_after(cyc);
    h = ((hi & ~xo) | (lo & xo)) & eh;
    l = ((lo & ~xo) | (hi & xo)) & el;
    if (ch) h = h & {3{car}};
    if (cl) l = l & {3{car}};
    it.due = cyc + 1; it.hi = h; it.lo = l; it.req = req;
    sb.push_back(it);
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
  endtask

  task automatic do_reset(input logic [7:0] n);
    sb.delete();
    @(negedge clk);
    rst_n = 1'b0; div_i = n; half_len = 4 * (int'(n) + 1);
    hi_i = '1; lo_i = '1; eh_i = '1; el_i = '1; xo_i = '0;
    ch_i = 0; cl_i = 0; trip_n = 1; clr_i = 0;
    repeat (2) @(negedge clk);
    cmp("R1", "hi_rst", int'(hi_o), 0);
    cmp("R1", "lo_rst", int'(lo_o), 0);
    cmp("R1", "flag_rst", int'(flag_o), 0);
    cmp("R1", "lvl_rst", int'(lvl_o), 1);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; trip_n = 1; clr_i = 0;
    do_reset(8'd0);

    // R2: straight path, one cycle latency
    drive(3'b101, 3'b010, '1, '1, '0, 0, 0, "R2");
    drive(3'b011, 3'b100, '1, '1, '0, 0, 0, "R2");
    drive(3'b000, 3'b111, '1, '1, '0, 0, 0, "R2");
    drive(3'b110, 3'b001, '1, '1, '0, 0, 0, "R2");
    // R3: crossover per pair
    drive(3'b101, 3'b010, '1, '1, 3'b111, 0, 0, "R3");
    drive(3'b110, 3'b000, '1, '1, 3'b010, 0, 0, "R3");
    drive(3'b001, 3'b110, '1, '1, 3'b100, 0, 0, "R3");
    // R4: enables act on pins after crossover
    drive(3'b111, 3'b111, 3'b010, 3'b101, '0, 0, 0, "R4");
    drive(3'b111, 3'b000, 3'b011, 3'b110, 3'b101, 0, 0, "R4");
    drive(3'b000, 3'b111, 3'b000, 3'b111, 3'b111, 0, 0, "R4");
    drain();

    // R5/R6/R7 with N=0 (half period 4)
    do_reset(8'd0);
    for (int i = 0; i < 20; i++) drive('1, '1, '1, '1, '0, 1, 0, "R6");
    for (int i = 0; i < 16; i++) drive('1, '1, '1, '1, '0, 0, 1, "R7");
    for (int i = 0; i < 12; i++) drive(3'b101, 3'b010, '1, '1, 3'b111, 1, 1, "R5");
    drain();
    // N=2 (half period 12)
    do_reset(8'd2);
    for (int i = 0; i < 40; i++) drive('1, '1, '1, '1, '0, 1, 1, "R5");
    drain();

    // trip sequence
    do_reset(8'd0);
    drive('1, '1, '1, '1, '0, 0, 0, "R2");
    drain();
    @(negedge clk); #2; trip_n = 0; #1;
    cmp("R8", "hi_async", int'(hi_o), 0);
    cmp("R8", "lo_async", int'(lo_o), 0);
    @(negedge clk);
    cmp("R9", "lvl_1edge", int'(lvl_o), 1);
    cmp("R10", "flag_early", int'(flag_o), 0);
    @(negedge clk);
    cmp("R9", "lvl_2edge", int'(lvl_o), 0);
    @(negedge clk);
    cmp("R10", "flag_set", int'(flag_o), 1);
    #2 clr_i = 1;
    @(negedge clk); #2 clr_i = 0;
    cmp("R10", "clr_ignored_low", int'(flag_o), 1);
    trip_n = 1; #1;
    cmp("R10", "hi_held", int'(hi_o), 0);
    cmp("R10", "lo_held", int'(lo_o), 0);
    @(negedge clk);
    cmp("R9", "lvl_rise_1edge", int'(lvl_o), 0);
    @(negedge clk);
    cmp("R9", "lvl_rise_2edge", int'(lvl_o), 1);
    cmp("R10", "flag_kept", int'(flag_o), 1);
    cmp("R10", "hi_still_off", int'(hi_o), 0);
    #2 clr_i = 1;
    @(negedge clk); #2 clr_i = 0;
    cmp("R10", "flag_cleared", int'(flag_o), 0);
    cmp("R10", "hi_resumed", int'(hi_o), 7);
    cmp("R10", "lo_resumed", int'(lo_o), 7);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule